// File: doc/BRIEF.md
# Chip-Select Access Permission Monitor

This block sits next to a chip-select decoder that serves eight external regions. Each region carries a two-bit permission code: read/write, read-only or write-only. The decoder presents each external access to the monitor as a valid/ready request that carries the region number and the direction. The monitor decides whether the request may be accepted.

The monitor then checks the direction against the region's permission. A read from a write-only region raises a sticky write-only error flag. A write to a read-only region raises a sticky read-only error flag. The number of the offending region is captured next to the flags. A violating access still completes normally. Raising a bus error is left to separate logic outside this block, and the flags are set whatever that logic's enable says.

A host reaches two registers over a simple register port with no wait states. The control word holds a global master enable and a separate boot-region enable. The status word holds the two flags and the captured region number. Software clears each flag by writing one to it.

Back-pressure rules for the request stream:
- `acc_ready` depends only on the region number and the two enables, never on `acc_valid`.
- A request is accepted in the cycle where `acc_valid` and `acc_ready` are both high.
- While a request is stalled, the requester holds `acc_cs` and `acc_write` stable.
- Register reads and writes are never stalled.

Top module: `cs_perm_monitor`

## Requirements
- R1: A request to region 1..7 is accepted (`acc_ready`=1) only when the master enable (control bit 0) is 1. When it is 0, `acc_ready` stays low for as long as `acc_valid` is held, and a stalled request sets no flag.
- R2: For region 0, `acc_ready` equals the boot enable (control bit 1), whatever the master enable is.
- R3: An accepted read to a region coded 2'b10 (write-only) sets the write-only flag. This flag is status bit 2 in MSB-0 numbering, which is `reg_rdata[29]`, and it reads back in the cycle after the handshake.
- R4: An accepted write to a region coded 2'b01 (read-only) sets the read-only flag. This flag is status bit 3 in MSB-0 numbering, which is `reg_rdata[28]`.
- R5: The following set no flag and are accepted as normal:
  - accesses to regions coded 2'b00 or 2'b11 (read/write);
  - writes to write-only regions;
  - reads from read-only regions.
  Violating accesses are also accepted as normal.
- R6: Each flag stays set until a status write carries 1 in that flag's bit. Writing 0 to a flag bit leaves it unchanged.
- R7: If a violation and a clearing write of the same flag fall in the same cycle, the flag stays set.
- R8: The error region field is status bits 5..7 in MSB-0 numbering, which is `reg_rdata[26:24]`. It is loaded with the region number only when a violation occurs while both flags are clear. At all other times it holds its value, so it keeps the first error until both flags have been cleared.
- R9: Register map (word index on `reg_addr`):
  - index 0 is control: master enable at bit 0, reset 0; boot enable at bit 1, reset 1.
  - index 1 is status, which resets to zero.
  - every other index reads zero, and every unassigned bit reads zero.
  Register access works whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| region_mode | input | 16 | Per-region permission, region i at bits [2i+1:2i] |
| acc_valid | input | 1 | External access request present |
| acc_ready | output | 1 | Request accepted this cycle if valid |
| acc_cs | input | 3 | Region number of the request |
| acc_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
Some rules are checked by the assertions on every cycle:
- disabled regions refuse requests;
- region 0 follows only its own enable;
- every accepted violation shows up as a set flag one cycle later;
- a set flag survives any cycle without a clearing write;
- the region field is frozen while either flag is up.

Other behaviour can only be shown by the bench's scenarios:
- the exact status and control words seen through the register port;
- that legal directions set nothing;
- that writing zero leaves a flag alone;
- the same-cycle set/clear race;
- a request stalled under back-pressure that completes once the enable is raised.

// File: rtl/csmon_pkg.sv
package csmon_pkg;
  typedef enum logic [1:0] {
    PERM_RW   = 2'b00,
    PERM_RO   = 2'b01,
    PERM_WO   = 2'b10,
    PERM_RW_A = 2'b11
  } perm_e;

  localparam int DATA_W      = 32;
  localparam int STAT_WO_BIT = 29;  // MSB-0 bit 2
  localparam int STAT_RO_BIT = 28;  // MSB-0 bit 3
  localparam int STAT_CS_LSB = 24;  // MSB-0 bits 5..7
  localparam int CTRL_ME_BIT = 0;
  localparam int CTRL_BE_BIT = 1;
endpackage

// File: rtl/cs_access_gate.sv
module cs_access_gate
  import csmon_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input  logic [2*NUM_CS-1:0] region_mode,
  input  logic                acc_valid,
  input  logic [CS_W-1:0]     acc_cs,
  input  logic                acc_write,
  input  logic                master_en,
  input  logic                boot_en,
  output logic                acc_ready,
  output logic                wo_viol,
  output logic                ro_viol
);
  logic [NUM_CS-1:0] region_open;
  logic [NUM_CS-1:0] rd_forbidden;
  logic [NUM_CS-1:0] wr_forbidden;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_region
    perm_e mode;
    assign mode = perm_e'(region_mode[2*g +: 2]);
    if (g == 0) begin : g_boot
      assign region_open[g] = boot_en;
    end else begin : g_plain
      assign region_open[g] = master_en;
    end
    assign rd_forbidden[g] = (mode == PERM_WO);
    assign wr_forbidden[g] = (mode == PERM_RO);
  end

  logic open_sel, rd_bad, wr_bad;
  always_comb begin
    open_sel = 1'b0;
    rd_bad   = 1'b0;
    wr_bad   = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (acc_cs == CS_W'(i)) begin
        open_sel = region_open[i];
        rd_bad   = rd_forbidden[i];
        wr_bad   = wr_forbidden[i];
      end
    end
  end

  logic fire;
  assign acc_ready = open_sel;
  assign fire      = acc_valid & open_sel;
  assign wo_viol   = fire & ~acc_write & rd_bad;
  assign ro_viol   = fire &  acc_write & wr_bad;
endmodule

// File: rtl/cs_err_status.sv
module cs_err_status #(
  parameter int CS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wo_set,
  input  logic            ro_set,
  input  logic [CS_W-1:0] viol_cs,
  input  logic            wo_clr,
  input  logic            ro_clr,
  output logic            wo_q,
  output logic            ro_q,
  output logic [CS_W-1:0] cs_q
);
  logic capture;
  assign capture = (wo_set | ro_set) & ~wo_q & ~ro_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wo_q <= 1'b0;
      ro_q <= 1'b0;
      cs_q <= '0;
    end else begin
      wo_q <= wo_set | (wo_q & ~wo_clr);
      ro_q <= ro_set | (ro_q & ~ro_clr);
      if (capture) cs_q <= viol_cs;
    end
  end
endmodule

// File: rtl/cs_ctrl_regs.sv
module cs_ctrl_regs
  import csmon_pkg::*;
#(
  parameter int AW   = 4,
  parameter int CS_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              wo_q,
  input  logic              ro_q,
  input  logic [CS_W-1:0]   cs_q,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              master_en,
  output logic              boot_en,
  output logic              wo_clr,
  output logic              ro_clr
);
  localparam logic [AW-1:0] ADDR_CTRL = AW'(0);
  localparam logic [AW-1:0] ADDR_STAT = AW'(1);

  logic ctrl_we, stat_we;
  assign ctrl_we = reg_wr & (reg_addr == ADDR_CTRL);
  assign stat_we = reg_wr & (reg_addr == ADDR_STAT);
  assign wo_clr  = stat_we & reg_wdata[STAT_WO_BIT];
  assign ro_clr  = stat_we & reg_wdata[STAT_RO_BIT];

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_en <= 1'b0;
      boot_en   <= 1'b1;
    end else if (ctrl_we) begin
      master_en <= reg_wdata[CTRL_ME_BIT];
      boot_en   <= reg_wdata[CTRL_BE_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CTRL) begin
      reg_rdata[CTRL_ME_BIT] = master_en;
      reg_rdata[CTRL_BE_BIT] = boot_en;
    end else if (reg_addr == ADDR_STAT) begin
      reg_rdata[STAT_WO_BIT] = wo_q;
      reg_rdata[STAT_RO_BIT] = ro_q;
      reg_rdata[STAT_CS_LSB +: CS_W] = cs_q;
    end
  end
endmodule

// File: rtl/cs_perm_monitor.sv
module cs_perm_monitor
  import csmon_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int AW     = 4,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NUM_CS-1:0] region_mode,
  input  logic                acc_valid,
  output logic                acc_ready,
  input  logic [CS_W-1:0]     acc_cs,
  input  logic                acc_write,
  input  logic [AW-1:0]       reg_addr,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata
);
  logic master_en, boot_en, wo_viol, ro_viol;
  logic wo_clr, ro_clr, wo_q, ro_q;
  logic [CS_W-1:0] cs_q;

  cs_access_gate #(.NUM_CS(NUM_CS), .CS_W(CS_W)) gate_i (
    .region_mode(region_mode), .acc_valid(acc_valid), .acc_cs(acc_cs),
    .acc_write(acc_write), .master_en(master_en), .boot_en(boot_en),
    .acc_ready(acc_ready), .wo_viol(wo_viol), .ro_viol(ro_viol)
  );

  cs_err_status #(.CS_W(CS_W)) stat_i (
    .clk(clk), .rst_n(rst_n), .wo_set(wo_viol), .ro_set(ro_viol),
    .viol_cs(acc_cs), .wo_clr(wo_clr), .ro_clr(ro_clr),
    .wo_q(wo_q), .ro_q(ro_q), .cs_q(cs_q)
  );

  cs_ctrl_regs #(.AW(AW), .CS_W(CS_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .wo_q(wo_q), .ro_q(ro_q), .cs_q(cs_q),
    .reg_rdata(reg_rdata), .master_en(master_en), .boot_en(boot_en),
    .wo_clr(wo_clr), .ro_clr(ro_clr)
  );

  AST_OFF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_en && acc_cs != '0) |-> !acc_ready);  // R1
  AST_BOOT_OWN_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cs == '0) |-> (acc_ready == boot_en));  // R2
  AST_WO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wo_viol |=> wo_q);  // R3
  AST_RO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ro_viol |=> ro_q);  // R4
  AST_WO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wo_q && !wo_clr) |=> wo_q);  // R6
  AST_RO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_q && !ro_clr) |=> ro_q);  // R6
  AST_CS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wo_q || ro_q) |=> $stable(cs_q));  // R8
endmodule

// File: tb/cs_perm_monitor_tb_top.sv
module cs_perm_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] region_mode = 16'h49E4;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [2:0]  acc_cs = '0;
  logic        acc_write = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cs_perm_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .region_mode(region_mode),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_cs(acc_cs),
    .acc_write(acc_write), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {me, be, cs[2:0], write, exp_ready, exp_wo, exp_ro}
  localparam logic [8:0] VEC [13] = '{
    9'b1_1_010_0_1_1_0,
    9'b1_1_010_1_1_0_0,
    9'b1_1_001_1_1_0_1,
    9'b1_1_001_0_1_0_0,
    9'b1_1_100_1_1_0_1,
    9'b1_1_101_0_1_1_0,
    9'b1_1_011_1_1_0_0,
    9'b1_1_110_0_1_0_0,
    9'b0_1_010_0_0_0_0,
    9'b0_1_000_0_1_0_0,
    9'b1_0_000_1_0_0_0,
    9'b0_0_000_0_0_0_0,
    9'b1_1_111_1_1_0_1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic one_access(input logic [2:0] cs, input logic wr);
    @(negedge clk);
    acc_valid = 1'b1; acc_cs = cs; acc_write = wr;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rd_reg(4'd0, rd); chk("R9 ctrl reset", rd, 32'h0000_0002);
    rd_reg(4'd1, rd); chk("R9 status reset", rd, 32'h0);
    rd_reg(4'd2, rd); chk("R9 unmapped reads zero", rd, 32'h0);
    wr_reg(4'd0, 32'hFFFF_FFFC);
    rd_reg(4'd0, rd); chk("R9 ctrl write with enables off", rd, 32'h0);
    wr_reg(4'd0, 32'h2);

    // vector table
    foreach (VEC[k]) begin
      logic me, be, wr, er, ew, eo;
      logic [2:0] cs;
      {me, be, cs, wr, er, ew, eo} = VEC[k];
      wr_reg(4'd1, 32'h3000_0000);
      wr_reg(4'd0, {30'b0, be, me});
      @(negedge clk);
      acc_valid = 1'b1; acc_cs = cs; acc_write = wr;
      #1 chk((cs == 3'd0) ? "R2 ready" : "R1 ready", {31'b0, acc_ready}, {31'b0, er});
      @(negedge clk);
      acc_valid = 1'b0;
      rd_reg(4'd1, rd);
      if (ew || eo)
        chk(ew ? "R3 flag+R8 cs" : "R4 flag+R8 cs", rd,
            {2'b00, ew, eo, 1'b0, cs, 24'h0});
      else
        chk("R5 no flag", rd & 32'h3000_0000, 32'h0);
    end

    // R6 sticky, write-zero ignored
    wr_reg(4'd1, 32'h3000_0000);
    wr_reg(4'd0, 32'h3);
    one_access(3'd2, 1'b0);
    wr_reg(4'd1, 32'h0);
    rd_reg(4'd1, rd); chk("R6 write 0 ignored", rd, 32'h2200_0000);
    wr_reg(4'd1, 32'h1000_0000);
    rd_reg(4'd1, rd); chk("R6 other bit clear ignored", rd, 32'h2200_0000);
    wr_reg(4'd1, 32'h2000_0000);
    rd_reg(4'd1, rd); chk("R6 write 1 clears", rd, 32'h0200_0000);

    // R8 first error kept
    one_access(3'd5, 1'b0);
    rd_reg(4'd1, rd); chk("R8 capture 5", rd, 32'h2500_0000);
    one_access(3'd7, 1'b1);
    rd_reg(4'd1, rd); chk("R8 field held", rd, 32'h3500_0000);
    wr_reg(4'd1, 32'h3000_0000);
    rd_reg(4'd1, rd); chk("R8 field kept after clear", rd, 32'h0500_0000);
    one_access(3'd1, 1'b1);
    rd_reg(4'd1, rd); chk("R8 new capture", rd, 32'h1100_0000);

    // R7 same-cycle set and clear
    @(negedge clk);
    reg_addr = 4'd1; reg_wdata = 32'h1000_0000; reg_wr = 1'b1;
    acc_valid = 1'b1; acc_cs = 3'd4; acc_write = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; acc_valid = 1'b0;
    rd_reg(4'd1, rd); chk("R7 set wins", rd, 32'h1100_0000);
    wr_reg(4'd1, 32'h1000_0000);
    rd_reg(4'd1, rd); chk("R7 plain clear", rd, 32'h0100_0000);

    // R1 back-pressure then release
    wr_reg(4'd0, 32'h2);
    @(negedge clk);
    acc_valid = 1'b1; acc_cs = 3'd2; acc_write = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1 chk("R1 stalled", {31'b0, acc_ready}, 32'h0);
    end
    rd_reg(4'd1, rd); chk("R1 stall sets nothing", rd & 32'h3000_0000, 32'h0);
    wr_reg(4'd0, 32'h3);
    #1 chk("R1 released", {31'b0, acc_ready}, 32'h1);
    @(negedge clk);
    acc_valid = 1'b0;
    rd_reg(4'd1, rd); chk("R1 released access R3 flag", rd, 32'h2200_0000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule